// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the control and status word of a small floating-point coprocessor. The word carries a three-bit rounding code, five trap-enable bits and five sticky exception flags. The arithmetic units are outside the block. They receive the decoded rounding mode and the trap enables from it. They return one-cycle exception pulses, and each pulse sets the matching flag.

Software writes the whole 32-bit word in one cycle. Only the rounding and trap-enable bits are stored; every other written bit is dropped. The read port is combinational. It returns the stored control bits with the live flag vector merged in at bits [14:10]. The flag state is loaded from the trap-enable field of each written value, so a write is also the only way to clear flags short of reset.

The active rounding mode is a separate register. It is re-decoded only when a write changes the rounding code. Codes 4 to 7 have no mode: writing one raises an error output and leaves the previous mode in force.

Top module: `fp_status_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, until the first write or pulse: rd_data_o is 0, rnd_mode_o is 0 (nearest-even), rnd_err_o is 0 and trap_en_o is 0.
- R2: A write stores only bits [2:0] (rounding code) and [9:5] (trap enables) of wr_data_i, visible on rd_data_o from the next cycle. rd_data_o bits [4:3] and [31:15] always read 0. Control bits do not change without a write.
- R3: A write that changes the rounding code to 0, 1, 2 or 3 sets rnd_mode_o to 0 (nearest-even), 1 (toward zero), 2 (toward +inf) or 3 (toward -inf) from the next cycle, and clears rnd_err_o.
- R4: A write that changes the rounding code to 4, 5, 6 or 7 sets rnd_err_o from the next cycle and leaves rnd_mode_o at its previous value.
- R5: A write whose rounding code equals the stored code leaves rnd_mode_o and rnd_err_o unchanged.
- R6: On a write, the flag vector is loaded from wr_data_i[9:5] and appears at rd_data_o[14:10] from the next cycle.
- R7: A pulse on exc_i[k] sets flag k (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact) from the next cycle. Flags stay set until a write or a reset.
- R8: rd_data_o equals the stored control bits ORed with the flag vector shifted to bits [14:10], with no extra read latency.
- R9: A pulse in the same cycle as a write is ORed into the flag value loaded by that write, not lost.
- R10: trap_en_o equals stored bits [9:5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Word to write |
| rd_data_o | output | 32 | Stored control bits merged with live flags |
| exc_i | input | 5 | Exception pulses from the arithmetic units |
| rnd_mode_o | output | 2 | Active rounding mode |
| rnd_err_o | output | 1 | Last decoded rounding code was unsupported |
| trap_en_o | output | 5 | Trap-enable bits |

## Verification
The hardest situation to reach is a stored rounding code that differs from the active mode. This happens only after an unsupported code has been written, and it is the one case where the rule that re-decoding needs a changed field can be observed. The stimulus first writes a supported code and then an unsupported one. It then writes the same unsupported code again with other trap bits, and checks that both the error and the old mode hold. It then moves to a second unsupported code and back to a supported one. A flag pulse is also placed in the same cycle as a write, to check that the OR with the loaded value wins over the reload.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int WORD_W   = 32;
  localparam int RND_W    = 3;
  localparam int FLAG_N   = 5;
  localparam int RND_LSB  = 0;
  localparam int TRAP_LSB = 5;
  localparam int FLAG_LSB = 10;

  localparam logic [WORD_W-1:0] RND_MASK  = WORD_W'(((1 << RND_W) - 1) << RND_LSB);
  localparam logic [WORD_W-1:0] TRAP_MASK = WORD_W'(((1 << FLAG_N) - 1) << TRAP_LSB);
  localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(((1 << FLAG_N) - 1) << FLAG_LSB);
  localparam logic [WORD_W-1:0] CTRL_MASK = RND_MASK | TRAP_MASK;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpcsr_rnd_decode.sv
module fpcsr_rnd_decode
  import fpcsr_pkg::*;
(
  input  logic [RND_W-1:0] code_i,
  output rnd_mode_e        mode_o,
  output logic             unsup_o
);
  always_comb begin
    unsup_o = 1'b0;
    mode_o  = RM_NEAR_EVEN;
    case (code_i)
      3'd0:    mode_o = RM_NEAR_EVEN;
      3'd1:    mode_o = RM_TO_ZERO;
      3'd2:    mode_o = RM_UP;
      3'd3:    mode_o = RM_DOWN;
      default: unsup_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpcsr_rnd_track.sv
module fpcsr_rnd_track
  import fpcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RND_W-1:0] new_code_i,
  input  logic [RND_W-1:0] cur_code_i,
  output rnd_mode_e        mode_o,
  output logic             err_o
);
  rnd_mode_e dec_mode;
  logic      dec_unsup;
  logic      redecode;
  rnd_mode_e mode_q;
  logic      err_q;

  fpcsr_rnd_decode u_dec (
    .code_i (new_code_i),
    .mode_o (dec_mode),
    .unsup_o(dec_unsup)
  );

  // re-decode only when the field actually changes
  assign redecode = wr_en_i && (new_code_i != cur_code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RM_NEAR_EVEN;
      err_q  <= 1'b0;
    end else if (redecode) begin
      err_q <= dec_unsup;
      if (!dec_unsup) mode_q <= dec_mode;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && new_code_i == cur_code_i) |=> ($stable(mode_q) && $stable(err_q)));

  p_bad_keeps_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && new_code_i != cur_code_i && new_code_i[2]) |=> (err_q && $stable(mode_q)));
endmodule

// File: rtl/fpcsr_flag_accum.sv
module fpcsr_flag_accum
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FLAG_N-1:0] load_val_i,
  input  logic [FLAG_N-1:0] exc_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] flags_q;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flags_q[i] <= 1'b0;
      else if (load_i) flags_q[i] <= load_val_i[i] | exc_i[i];
      else             flags_q[i] <= flags_q[i] | exc_i[i];
    end
  end

  assign flags_o = flags_q;

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_pulse_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exc_i) |=> ((flags_q & $past(exc_i)) == $past(exc_i)));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flags_q == ($past(load_val_i) | $past(exc_i))));
endmodule

// File: rtl/fpcsr_ctrl_store.sv
module fpcsr_ctrl_store
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] ctrl_o
);
  logic [WORD_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i & CTRL_MASK;
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [FLAG_N-1:0] exc_i,
  output logic [1:0]        rnd_mode_o,
  output logic              rnd_err_o,
  output logic [FLAG_N-1:0] trap_en_o
);
  logic [WORD_W-1:0] ctrl;
  logic [FLAG_N-1:0] flags;
  rnd_mode_e         mode;

  fpcsr_ctrl_store u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl)
  );

  fpcsr_rnd_track u_rnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .new_code_i(wr_data_i[RND_LSB +: RND_W]),
    .cur_code_i(ctrl[RND_LSB +: RND_W]),
    .mode_o    (mode),
    .err_o     (rnd_err_o)
  );

  // flag state reloads from the trap-enable field of each written word
  fpcsr_flag_accum u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_en_i),
    .load_val_i(wr_data_i[TRAP_LSB +: FLAG_N]),
    .exc_i     (exc_i),
    .flags_o   (flags)
  );

  assign rd_data_o  = ctrl | (WORD_W'(flags) << FLAG_LSB);
  assign rnd_mode_o = mode;
  assign trap_en_o  = ctrl[TRAP_LSB +: FLAG_N];

  p_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~(CTRL_MASK | FLAG_MASK)) == '0);

  p_err_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_err_o |-> rd_data_o[RND_LSB + 2]);
endmodule

// File: tb/fp_status_ctrl_tb.sv
module fp_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  exc = '0;
  logic [1:0]  rnd_mode;
  logic        rnd_err;
  logic [4:0]  trap_en;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  fp_status_ctrl u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .exc_i     (exc),
    .rnd_mode_o(rnd_mode),
    .rnd_err_o (rnd_err),
    .trap_en_o (trap_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic do_write(logic [31:0] d, logic [4:0] e = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; exc = e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; exc = '0;
  endtask

  task automatic do_pulse(logic [4:0] e);
    @(negedge clk);
    exc = e;
    @(negedge clk);
    exc = '0;
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 mode", 32'(rnd_mode), 32'd0);
    check("R1 err", 32'(rnd_err), 32'd0);
    check("R1 trap_en", 32'(trap_en), 32'd0);
  endtask

  task automatic t_modes;
    do_write(32'd1); check("R3 code1", 32'(rnd_mode), 32'd1);
    do_write(32'd2); check("R3 code2", 32'(rnd_mode), 32'd2);
    do_write(32'd3); check("R3 code3", 32'(rnd_mode), 32'd3);
    check("R3 err clear", 32'(rnd_err), 32'd0);
    do_write(32'd0); check("R3 code0", 32'(rnd_mode), 32'd0);
  endtask

  task automatic t_mask;
    do_write(32'hFFFF_FFFF);
    check("R2/R6/R8 all ones", rd_data, 32'h0000_7FE7);
    check("R10 trap_en", 32'(trap_en), 32'h1F);
    check("R4 code7 err", 32'(rnd_err), 32'd1);
    check("R4 code7 mode kept", 32'(rnd_mode), 32'd0);
    do_write(32'h0);
    check("R2 cleared", rd_data, 32'h0);
    check("R3 err cleared", 32'(rnd_err), 32'd0);
  endtask

  task automatic t_unsupported;
    do_write(32'd2);
    do_write(32'd4);
    check("R4 code4 err", 32'(rnd_err), 32'd1);
    check("R4 code4 mode", 32'(rnd_mode), 32'd2);
    do_write(32'h24);
    check("R5 same bad code err", 32'(rnd_err), 32'd1);
    check("R5 same bad code mode", 32'(rnd_mode), 32'd2);
    check("R6 flags from trap", rd_data, 32'h0000_0424);
    do_write(32'd5);
    check("R4 code5 err", 32'(rnd_err), 32'd1);
    check("R4 code5 mode", 32'(rnd_mode), 32'd2);
    do_write(32'd3);
    check("R3 back to supported", 32'(rnd_mode), 32'd3);
    check("R3 err drop", 32'(rnd_err), 32'd0);
    do_write(32'h3E3);
    check("R5 same good code", 32'(rnd_mode), 32'd3);
    check("R10 trap only", 32'(trap_en), 32'h1F);
    do_write(32'h0);
  endtask

  task automatic t_sticky;
    do_pulse(5'b00100);
    check("R7/R8 overflow flag", rd_data, 32'h0000_1000);
    do_pulse(5'b00001);
    check("R7 invalid flag adds", rd_data, 32'h0000_1400);
    repeat (5) @(negedge clk);
    check("R7 sticky", rd_data, 32'h0000_1400);
    do_write(32'h0);
    check("R7 cleared by write", rd_data, 32'h0);
  endtask

  task automatic t_same_cycle;
    do_write(32'h20, 5'b10000);
    check("R9 pulse with write", rd_data, 32'h0000_4420);
    do_write(32'h0);
  endtask

  task automatic t_reset_mid;
    do_write(32'h41);
    do_pulse(5'b01000);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset rd", rd_data, 32'h0);
    check("R1 async reset mode", 32'(rnd_mode), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_mask();
    t_unsupported();
    t_sticky();
    t_same_cycle();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule